// File: doc/BRIEF.md
# Swapped-Select Nibble Bank Register Decoder

This block sits on the CPU write path of a cartridge banking controller. It watches writes in the upper half of the address space, sorts them by their top address nibble, and loads one of several bank registers: two 8-bit program-bank registers, a mirroring register, a miscellaneous control register, and eight 12-bit character-bank registers. Decoding is registered: a write sampled on a rising clock edge shows up on the outputs right after that edge.

Two address lines, A2 and A3, act as a 2-bit register select inside a region. Their roles swap depending on A11, so the same register can be reached from two address patterns. Each character-bank register is 12 bits wide. A write with select bit 0 clear loads its low nibble only. A write with select bit 0 set loads the whole data byte above that nibble and keeps the nibble. Writes are taken only while the mode-enable input is high. Combining bank numbers with outer masks, and the interrupt counter in the top 4 KiB, are handled elsewhere.

Top module: `nbd_top`

## Requirements
- R1: After reset, both program-bank registers, the mirroring and misc registers, the slot-swap output and all eight character-bank registers read zero.
- R2: A write changes a register only when `wr_en` and `mode_en` are both high at the rising edge. With either one low, every output keeps its value.
- R3: A write with address bits [15:12] equal to 0x8 or 0xA loads the full data byte into program-bank register 0 when A13 is 0 and into register 1 when A13 is 1. This holds whatever the state of A2, A3 and A11.
- R4: The select pair is remapped by A11. With A11 = 1, select bit 0 is A3 and select bit 1 is A2. With A11 = 0, select bit 0 is A2 and select bit 1 is A3.
- R5: In region 0x9, select bit 1 = 0 loads the mirroring register. Select bit 1 = 1 with select bit 0 = 0 loads the misc register. Both select bits set changes neither register.
- R6: In regions 0xB to 0xE, the character register index has bits [2:1] equal to the region number minus 0xB. Its bit 0 is A11 OR select bit 1.
- R7: A character write with select bit 0 = 0 sets bits [3:0] of the indexed register to data[3:0] and leaves bits [11:4] unchanged.
- R8: A character write with select bit 0 = 1 sets bits [11:4] of the indexed register to data[7:0] and leaves bits [3:0] unchanged.
- R9: `slot_swap` always equals bit 1 of the misc register.
- R10: Writes with address bits [15:12] equal to 0xF, or below 0x8, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| mode_en | input | 1 | High while this register set owns the write path |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| prg_bank0 | output | 8 | Program-bank register 0 |
| prg_bank1 | output | 8 | Program-bank register 1 |
| mirror_reg | output | 8 | Mirroring register |
| misc_reg | output | 8 | Miscellaneous control register |
| slot_swap | output | 1 | Program slot swap control (misc bit 1) |
| chr_banks | output | 8x12 | Character-bank registers, entry i at bits [12*i+11:12*i] |

## Verification
Every register responds with a latency of one edge. A write presented at a falling edge is captured at the next rising edge and is visible from the following falling edge, and that is where the bench samples. Stimulus changes only on falling edges. Each table vector is checked one cycle after its write strobe, against the single register that the vector names. The checks for ignored writes read the register that could have been disturbed at that same cycle, before any other write is issued. The embedded properties use the same one-edge window through `|=>` and `$past` of depth one.

// File: rtl/nbd_pkg.sv
package nbd_pkg;
  localparam int NBD_CHR_CNT = 8;
  localparam int NBD_CHR_IDX_W = $clog2(NBD_CHR_CNT);

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_PRG,
    TGT_MIRROR,
    TGT_MISC,
    TGT_CHR
  } nbd_tgt_e;

  typedef struct packed {
    nbd_tgt_e                  tgt;
    logic                      prg_idx;
    logic [NBD_CHR_IDX_W-1:0]  chr_idx;
    logic                      hi_part;
  } nbd_dec_t;
endpackage

// File: rtl/nbd_addr_decode.sv
module nbd_addr_decode
  import nbd_pkg::*;
(
  input  logic [15:0] addr,
  output logic        sel0,
  output logic        sel1,
  output nbd_dec_t    dec
);
  logic [3:0] region;
  logic [3:0] chr_off;
  logic       unused_addr_bits;

  assign region  = addr[15:12];
  assign chr_off = region - 4'hB;

  // A11 swaps the roles of A2 and A3
  always_comb begin
    if (addr[11]) begin
      sel0 = addr[3];
      sel1 = addr[2];
    end else begin
      sel0 = addr[2];
      sel1 = addr[3];
    end
  end

  always_comb begin
    dec         = '0;
    dec.tgt     = TGT_NONE;
    dec.prg_idx = addr[13];
    dec.chr_idx = {chr_off[NBD_CHR_IDX_W-2:0], addr[11] | sel1};
    dec.hi_part = sel0;
    unique case (region)
      4'h8, 4'hA: dec.tgt = TGT_PRG;
      4'h9: begin
        if (!sel1)      dec.tgt = TGT_MIRROR;
        else if (!sel0) dec.tgt = TGT_MISC;
        else            dec.tgt = TGT_NONE;
      end
      4'hB, 4'hC, 4'hD, 4'hE: dec.tgt = TGT_CHR;
      default: dec.tgt = TGT_NONE;
    endcase
  end

  assign unused_addr_bits = ^{addr[10:4], addr[1:0]};
endmodule

// File: rtl/nbd_ctrl_regs.sv
module nbd_ctrl_regs
  import nbd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  nbd_dec_t      dec,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] prg0,
  output logic [DW-1:0] prg1,
  output logic [DW-1:0] mirror,
  output logic [DW-1:0] misc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prg0   <= '0;
      prg1   <= '0;
      mirror <= '0;
      misc   <= '0;
    end else if (we) begin
      case (dec.tgt)
        TGT_PRG: begin
          if (dec.prg_idx) prg1 <= d;
          else             prg0 <= d;
        end
        TGT_MIRROR: mirror <= d;
        TGT_MISC:   misc   <= d;
        default: ;
      endcase
    end
  end

  p_prg_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && dec.tgt == TGT_PRG) |=>
      (($past(dec.prg_idx) ? prg1 : prg0) == $past(d)))
    else $error("p_prg_load_r3");

  p_mirror_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && dec.tgt == TGT_MIRROR) |=> (mirror == $past(d)) && $stable(misc))
    else $error("p_mirror_load_r5");
endmodule

// File: rtl/nbd_chr_bank.sv
module nbd_chr_bank #(
  parameter int DW    = 8,
  parameter int LOW_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic                hi_part,
  input  logic [DW-1:0]       d,
  output logic [DW+LOW_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (we) begin
      if (hi_part) q[DW+LOW_W-1:LOW_W] <= d;
      else         q[LOW_W-1:0]        <= d[LOW_W-1:0];
    end
  end

  p_low_nibble_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !hi_part) |=>
      (q[LOW_W-1:0] == $past(d[LOW_W-1:0])) &&
      (q[DW+LOW_W-1:LOW_W] == $past(q[DW+LOW_W-1:LOW_W])))
    else $error("p_low_nibble_r7");

  p_high_part_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && hi_part) |=>
      (q[DW+LOW_W-1:LOW_W] == $past(d)) &&
      (q[LOW_W-1:0] == $past(q[LOW_W-1:0])))
    else $error("p_high_part_r8");
endmodule

// File: rtl/nbd_top.sv
module nbd_top
  import nbd_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LOW_W = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic                                 mode_en,
  input  logic [15:0]                          cpu_addr,
  input  logic [DW-1:0]                        cpu_data,
  output logic [DW-1:0]                        prg_bank0,
  output logic [DW-1:0]                        prg_bank1,
  output logic [DW-1:0]                        mirror_reg,
  output logic [DW-1:0]                        misc_reg,
  output logic                                 slot_swap,
  output logic [NBD_CHR_CNT-1:0][DW+LOW_W-1:0] chr_banks
);
  localparam int CHR_W = DW + LOW_W;

  nbd_dec_t dec;
  logic     sel0;
  logic     sel1;
  logic     we;

  assign we = wr_en && mode_en;

  nbd_addr_decode u_dec (
    .addr (cpu_addr),
    .sel0 (sel0),
    .sel1 (sel1),
    .dec  (dec)
  );

  nbd_ctrl_regs #(.DW(DW)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (we),
    .dec    (dec),
    .d      (cpu_data),
    .prg0   (prg_bank0),
    .prg1   (prg_bank1),
    .mirror (mirror_reg),
    .misc   (misc_reg)
  );

  for (genvar i = 0; i < NBD_CHR_CNT; i++) begin : g_chr
    logic bank_we;
    assign bank_we = we && (dec.tgt == TGT_CHR) &&
                     (dec.chr_idx == NBD_CHR_IDX_W'(i));
    nbd_chr_bank #(.DW(DW), .LOW_W(LOW_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (bank_we),
      .hi_part (dec.hi_part),
      .d       (cpu_data),
      .q       (chr_banks[i])
    );
  end

  assign slot_swap = misc_reg[1];

  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && mode_en) |=> $stable(prg_bank0) && $stable(prg_bank1) &&
      $stable(mirror_reg) && $stable(misc_reg) && $stable(chr_banks))
    else $error("p_gate_r2");

  p_outside_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:12] == 4'hF || !cpu_addr[15]) |=>
      $stable(prg_bank0) && $stable(prg_bank1) && $stable(mirror_reg) &&
      $stable(misc_reg) && $stable(chr_banks))
    else $error("p_outside_r10");

  p_sel_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:12] == 4'h9 && cpu_addr[3] && cpu_addr[2]) |=>
      $stable(mirror_reg) && $stable(misc_reg))
    else $error("p_sel_both_r5");

  p_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_swap == misc_reg[1])
    else $error("p_swap_r9");

  p_remap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel0 ^ sel1) |-> ((cpu_addr[11] ? cpu_addr[3] : cpu_addr[2]) == sel0))
    else $error("p_remap_r4");

  logic [CHR_W-1:0] unused_chr_w;
  assign unused_chr_w = '0;
endmodule

// File: tb/nbd_top_test.sv
module nbd_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic mode_en = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0] cpu_data = '0;
  logic [7:0] prg_bank0, prg_bank1, mirror_reg, misc_reg;
  logic slot_swap;
  logic [7:0][11:0] chr_banks;

  int applied = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nbd_top uut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .mode_en (mode_en),
    .cpu_addr (cpu_addr), .cpu_data (cpu_data),
    .prg_bank0 (prg_bank0), .prg_bank1 (prg_bank1),
    .mirror_reg (mirror_reg), .misc_reg (misc_reg),
    .slot_swap (slot_swap), .chr_banks (chr_banks)
  );

  // {addr, data, register id, expected}; id 0 prg0, 1 prg1, 2 mirror, 3 misc, 4+i chr i
  localparam logic [39:0] VEC [NVEC] = '{
    {16'h8000, 8'h5A, 4'd0, 12'h05A},  // R3
    {16'hA000, 8'hC3, 4'd1, 12'h0C3},  // R3
    {16'hA004, 8'h11, 4'd1, 12'h011},  // R3
    {16'h9000, 8'h02, 4'd2, 12'h002},  // R5
    {16'h9008, 8'h07, 4'd3, 12'h007},  // R4 R5
    {16'h9804, 8'h44, 4'd3, 12'h044},  // R4 R5
    {16'h9004, 8'h99, 4'd2, 12'h099},  // R4 R5
    {16'h900C, 8'h55, 4'd3, 12'h044},  // R5 ignored
    {16'hB000, 8'h0F, 4'd4, 12'h00F},  // R7
    {16'hB004, 8'hAB, 4'd4, 12'hABF},  // R8
    {16'hB008, 8'h03, 4'd5, 12'h003},  // R6 R7
    {16'hB800, 8'h06, 4'd5, 12'h006},  // R4 R6
    {16'hB80C, 8'hFF, 4'd5, 12'hFF6},  // R6 R8
    {16'hE808, 8'h21, 4'd11, 12'h210}, // R4 R6 R8
    {16'hC004, 8'h7E, 4'd6, 12'h7E0},  // R6 R8
    {16'hD008, 8'h09, 4'd9, 12'h009},  // R6 R7
    {16'hF000, 8'h33, 4'd0, 12'h05A},  // R10
    {16'h6000, 8'h77, 4'd0, 12'h05A}   // R10
  };

  function automatic logic [11:0] read_reg(input logic [3:0] id);
    case (id)
      4'd0: return {4'h0, prg_bank0};
      4'd1: return {4'h0, prg_bank1};
      4'd2: return {4'h0, mirror_reg};
      4'd3: return {4'h0, misc_reg};
      default: return chr_banks[id - 4'd4];
    endcase
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic me, input logic we);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; mode_en = me; wr_en = we;
    @(negedge clk);
    wr_en = 1'b0; cpu_addr = 16'h0000;
    #1;
  endtask

  task automatic check_all_zero(input string req);
    for (int i = 0; i < 12; i++) check(req, read_reg(4'(i)), 12'h000);
    check(req, {11'h0, slot_swap}, 12'h000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check_all_zero("R1");
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      do_write(VEC[v][39:24], VEC[v][23:16], 1'b1, 1'b1);
      check($sformatf("R3-R10 vector %0d", v), read_reg(VEC[v][15:12]), VEC[v][11:0]);
    end

    // R2: mode disabled, then strobe low
    do_write(16'h8000, 8'hEE, 1'b0, 1'b1);
    check("R2 mode_en low", {4'h0, prg_bank0}, 12'h05A);
    do_write(16'hB000, 8'h01, 1'b1, 1'b0);
    check("R2 wr_en low", chr_banks[0], 12'hABF);

    // R9: misc bit1 drives slot_swap
    do_write(16'h9008, 8'h02, 1'b1, 1'b1);
    check("R9 swap set", {11'h0, slot_swap}, 12'h001);
    do_write(16'h9008, 8'hFD, 1'b1, 1'b1);
    check("R9 swap clear", {11'h0, slot_swap}, 12'h000);

    // R1: reset again clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    check_all_zero("R1 second reset");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      applied++;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule